// File: doc/BRIEF.md
# Memory Port with Burst Fetch

This block is one serialized access port in front of a private synchronous word store. Three request channels feed it, each with a valid/ready handshake: a packed burst descriptor, a single read address, and a write made of an address word and a data word that are accepted together. Every result leaves through one valid/ready output channel, which carries a data word and a one-bit flag. The flag tells a consumer whether the word is read data or the confirmation of a write.

A descriptor packs a start address and a word count. Accepting one starts a run of reads at consecutive addresses, one word per cycle while the consumer keeps taking them. A write commits its data and then reports the address just after the one written, which lets a producer chain sequential writes without doing its own arithmetic. The port performs one operation at a time and returns results in the order it accepted the requests. Reads outside the store return zero. Writes outside the store change nothing but are still confirmed.

Top module: `mem_burst_port`

## Requirements
- R1: A descriptor word is ADDR_W+CNT_W bits wide, with the start address in its upper ADDR_W bits and the word count in its lowest CNT_W bits. The default is 31+6 = 37 bits.
- R2: A descriptor with a count of N>0 produces N output words in order, taken from the start address and the N-1 addresses that follow it. Each word has flag 0.
- R3: An accepted read request produces one output word equal to the stored word at that address, with flag 0.
- R4: An accepted write stores its data and produces one output word equal to the write address plus one, computed modulo 2^ADDR_W and zero-extended, with flag 1.
- R5: A read at an address of DEPTH or above returns zero. This applies both to single reads and to burst words.
- R6: A write at an address of DEPTH or above leaves every stored word unchanged, and it still produces its R4 confirmation.
- R7: At most one request is accepted per cycle. Priority runs from a running burst, to a new descriptor, to a write (which needs both address and data valid), to a read.
- R8: While words of an accepted burst remain to be issued, no further descriptor is accepted.
- R9: A descriptor with a count of zero is consumed, produces no output, and leaves the port free to accept another descriptor in the next cycle.
- R10: While the output is valid and not accepted, its valid, data and flag hold their values, and no result is lost or duplicated under backpressure.
- R11: A synchronous active-high reset drops the output valid and abandons any running burst. The store's contents are not guaranteed after reset.
- R12: Results leave in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Burst descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_word | input | ADDR_W+CNT_W | Start address (upper bits) and count (low bits) |
| rd_valid | input | 1 | Read address offered |
| rd_ready | output | 1 | Read accepted |
| rd_addr | input | ADDR_W | Read address |
| wr_addr_valid | input | 1 | Write address offered |
| wr_addr_ready | output | 1 | Write address accepted |
| wr_addr | input | ADDR_W | Write address |
| wr_data_valid | input | 1 | Write data offered |
| wr_data_ready | output | 1 | Write data accepted |
| wr_data | input | DATA_W | Write data |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Read word or write confirmation |
| out_flag | output | 1 | 0 for read data, 1 for write confirmation |

## Verification
A corrupted burst counter or address shows up at once in the output stream. It appears as a missing, extra or misaddressed word, caught at the next handshake against the bench's queue of expected results. A wrong grant shows on the ready outputs in the same cycle. A bad value in the pipeline register shows as a word that changes while stalled, or as a wrong flag, in the cycle right after the request is accepted. Sweeps over the whole small store, including addresses past its end, expose errors in the range decode and in address aliasing through the next read of the affected word.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BURST = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } mp_op_e;
endpackage

// File: rtl/mp_arbiter.sv
module mp_arbiter
  import mp_pkg::*;
(
  input  logic   burst_busy,
  input  logic   slot_free,
  input  logic   desc_valid,
  input  logic   wa_valid,
  input  logic   wd_valid,
  input  logic   rd_valid,
  output logic   desc_ready,
  output logic   wr_ready,
  output logic   rd_ready,
  output mp_op_e op
);
  // Fixed priority: running burst, new descriptor, write pair, read.
  always_comb begin
    desc_ready = !burst_busy;
    wr_ready   = 1'b0;
    rd_ready   = 1'b0;
    op         = OP_IDLE;
    if (burst_busy) begin
      if (slot_free) op = OP_BURST;
    end else if (desc_valid) begin
      op = OP_IDLE; // descriptor load uses this cycle
    end else if (wa_valid && wd_valid) begin
      if (slot_free) begin
        wr_ready = 1'b1;
        op       = OP_WRITE;
      end
    end else if (rd_valid && slot_free) begin
      rd_ready = 1'b1;
      op       = OP_READ;
    end
  end
endmodule

// File: rtl/mp_burst_seq.sv
module mp_burst_seq #(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_cnt;
    end else if (step) begin
      remaining <= remaining - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      cur_addr <= load_addr;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
    end
  end

  assign busy = (remaining != '0);
endmodule

// File: rtl/mp_store.sv
module mp_store #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 37,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  // Single-clock, registered-read array suited to block RAM inference.
  always_ff @(posedge clk) begin
    if (we) cells[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[ridx];
  end
endmodule

// File: rtl/mem_burst_port.sv
module mem_burst_port
  import mp_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 6,
  parameter int DATA_W = 37,
  parameter int DEPTH  = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    desc_valid,
  output logic                    desc_ready,
  input  logic [ADDR_W+CNT_W-1:0] desc_word,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_addr_valid,
  output logic                    wr_addr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic                    wr_data_valid,
  output logic                    wr_data_ready,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_flag
);
  localparam int DESC_W = ADDR_W + CNT_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_LIM = (ADDR_W+1)'(DEPTH);

  mp_op_e            op;
  logic              burst_busy;
  logic [ADDR_W-1:0] burst_addr;
  logic              slot_free;
  logic              wr_grant;
  logic              desc_take;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_in_range;
  logic              mem_re;
  logic              mem_we;
  logic [DATA_W-1:0] mem_q;

  // Result stage ahead of the output port.
  logic              p_valid;
  logic              p_read;
  logic              p_oob;
  logic [ADDR_W-1:0] p_conf;

  assign slot_free = !p_valid || out_ready;

  mp_arbiter u_arb (
    .burst_busy (burst_busy),
    .slot_free  (slot_free),
    .desc_valid (desc_valid),
    .wa_valid   (wr_addr_valid),
    .wd_valid   (wr_data_valid),
    .rd_valid   (rd_valid),
    .desc_ready (desc_ready),
    .wr_ready   (wr_grant),
    .rd_ready   (rd_ready),
    .op         (op)
  );

  assign wr_addr_ready = wr_grant;
  assign wr_data_ready = wr_grant;
  assign desc_take     = desc_valid && desc_ready;

  mp_burst_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (desc_take),
    .load_addr (desc_word[DESC_W-1:CNT_W]),
    .load_cnt  (desc_word[CNT_W-1:0]),
    .step      (op == OP_BURST),
    .busy      (burst_busy),
    .cur_addr  (burst_addr)
  );

  always_comb begin
    case (op)
      OP_BURST: sel_addr = burst_addr;
      OP_WRITE: sel_addr = wr_addr;
      default:  sel_addr = rd_addr;
    endcase
  end

  assign sel_in_range = ({1'b0, sel_addr} < DEPTH_LIM);
  assign mem_re = ((op == OP_BURST) || (op == OP_READ)) && sel_in_range;
  assign mem_we = (op == OP_WRITE) && sel_in_range;

  mp_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .widx  (sel_addr[IDX_W-1:0]),
    .wdata (wr_data),
    .re    (mem_re),
    .ridx  (sel_addr[IDX_W-1:0]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
    end else if (slot_free) begin
      p_valid <= (op != OP_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (slot_free) begin
      p_read <= (op != OP_WRITE);
      p_oob  <= !sel_in_range;
      p_conf <= wr_addr + 1'b1;
    end
  end

  assign out_valid = p_valid;
  assign out_flag  = !p_read;
  assign out_data  = p_read ? (p_oob ? '0 : mem_q) : DATA_W'(p_conf);
endmodule

// File: rtl/mem_burst_port_chk.sv
module mem_burst_port_chk #(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 6,
  parameter int DATA_W = 37
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [CNT_W-1:0]  desc_cnt,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              wr_addr_valid,
  input logic              wr_addr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_data_valid,
  input logic              wr_data_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_flag
);
  logic d_hs, w_hs, r_hs;
  assign d_hs = desc_valid && desc_ready;
  assign w_hs = wr_addr_valid && wr_addr_ready && wr_data_valid && wr_data_ready;
  assign r_hs = rd_valid && rd_ready;

  p_one_accept_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({d_hs, w_hs, r_hs}));

  p_write_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_addr_ready || wr_data_ready) |-> (wr_addr_valid && wr_data_valid && !desc_valid));

  p_no_desc_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (d_hs && desc_cnt != '0) |=> !desc_ready);

  p_zero_count_free_r9: assert property (@(posedge clk) disable iff (rst)
    (d_hs && desc_cnt == '0) |=> desc_ready);

  p_hold_output_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flag)));

  p_read_flag_r3: assert property (@(posedge clk) disable iff (rst)
    r_hs |=> (out_valid && !out_flag));

  p_write_flag_r4: assert property (@(posedge clk) disable iff (rst)
    w_hs |=> (out_valid && out_flag));

  p_write_confirm_r4: assert property (@(posedge clk) disable iff (rst)
    w_hs |=> (out_data == DATA_W'(ADDR_W'($past(wr_addr) + 1'b1))));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind mem_burst_port mem_burst_port_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .desc_cnt      (desc_word[CNT_W-1:0]),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .wr_addr_valid (wr_addr_valid),
  .wr_addr_ready (wr_addr_ready),
  .wr_addr       (wr_addr),
  .wr_data_valid (wr_data_valid),
  .wr_data_ready (wr_data_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_flag      (out_flag)
);

// File: tb/test_mem_burst_port.sv
module test_mem_burst_port;
  localparam int AW  = 8;
  localparam int CW  = 4;
  localparam int DW  = 12;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic          desc_valid, desc_ready;
  logic [AW+CW-1:0] desc_word;
  logic          rd_valid, rd_ready;
  logic [AW-1:0] rd_addr;
  logic          wr_addr_valid, wr_addr_ready;
  logic [AW-1:0] wr_addr;
  logic          wr_data_valid, wr_data_ready;
  logic [DW-1:0] wr_data;
  logic          out_valid, out_ready, out_flag;
  logic [DW-1:0] out_data;

  mem_burst_port #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .DEPTH(DEP)) i_mem_burst_port (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_word(desc_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready), .wr_addr(wr_addr),
    .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_flag(out_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 0;
  logic [DW-1:0] model [DEP];
  logic [DW-1:0] eq_d [4096];
  logic          eq_f [4096];
  string         eq_t [4096];
  int qh = 0;
  int qt = 0;
  logic prev_stall = 1'b0;
  logic [DW-1:0] prev_d;
  logic prev_f;
  logic expect_busy = 1'b0;
  logic expect_free = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_model(input int a);
    int w = a & 255;
    return (w < DEP) ? model[w] : '0;
  endfunction

  task automatic push(input logic [DW-1:0] d, input logic f, input string t);
    eq_d[qt] = d; eq_f[qt] = f; eq_t[qt] = t; qt++;
  endtask

  task automatic step_cycle();
    bit hd, hw, hr;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ((cyc * 7) % 5) < 3;
      default: out_ready = 1'b0;
    endcase
    #1;
    if (expect_busy) begin chk(!desc_ready, "R8 descriptor refused during burst", desc_ready, 0); expect_busy = 0; end
    if (expect_free) begin chk(desc_ready, "R9 port free after empty descriptor", desc_ready, 1); expect_free = 0; end
    if (prev_stall)
      chk(out_valid && out_data == prev_d && out_flag == prev_f, "R10 hold while stalled",
          {out_valid, out_flag, out_data}, {1'b1, prev_f, prev_d});
    if (out_valid && out_ready) begin
      if (qh == qt) chk(0, "R12 unexpected result", out_data, 0);
      else begin
        chk(out_data == eq_d[qh] && out_flag == eq_f[qh], eq_t[qh], {out_flag, out_data}, {eq_f[qh], eq_d[qh]});
        qh++;
      end
    end
    if (wr_addr_ready || wr_data_ready)
      chk(!desc_valid && wr_addr_ready && wr_data_ready && wr_addr_valid && wr_data_valid,
          "R7 write grant", {desc_valid, wr_addr_ready, wr_data_ready}, 3'b011);
    if (rd_ready)
      chk(!desc_valid && !(wr_addr_valid && wr_data_valid), "R7 read grant",
          {desc_valid, wr_addr_valid, wr_data_valid}, 0);
    hd = desc_valid && desc_ready;
    hw = wr_addr_valid && wr_addr_ready && wr_data_valid && wr_data_ready;
    hr = rd_valid && rd_ready;
    if (hd) begin
      int a = int'(desc_word[AW+CW-1:CW]);
      int c = int'(desc_word[CW-1:0]);
      for (int i = 0; i < c; i++)
        push(rd_model(a + i), 1'b0, (((a + i) & 255) >= DEP) ? "R5 burst word past end" : "R2 burst word");
      if (c != 0) expect_busy = 1; else expect_free = 1;
    end
    if (hw) begin
      if (int'(wr_addr) < DEP) model[wr_addr] = wr_data;
      push(DW'(AW'(wr_addr + 1'b1)), 1'b1, (int'(wr_addr) >= DEP) ? "R6 discarded write confirm" : "R4 write confirm");
    end
    if (hr) push(rd_model(int'(rd_addr)), 1'b0, (int'(rd_addr) >= DEP) ? "R5 read past end" : "R3 read");
    prev_stall = out_valid && !out_ready;
    prev_d = out_data;
    prev_f = out_flag;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (hd) desc_valid = 1'b0;
    if (hw) begin wr_addr_valid = 1'b0; wr_data_valid = 1'b0; end
    if (hr) rd_valid = 1'b0;
  endtask

  task automatic run_until_taken();
    int n = 0;
    while ((desc_valid || rd_valid || wr_addr_valid || wr_data_valid) && n < 500) begin
      step_cycle(); n++;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((qh != qt || out_valid) && n < 500) begin step_cycle(); n++; end
    chk(qh == qt, "R12 all results delivered", qt - qh, 0);
  endtask

  task automatic put_desc(input int a, input int c);
    desc_word = {AW'(a), CW'(c)}; // R1: address in upper bits, count in low bits
    desc_valid = 1'b1;
  endtask
  task automatic put_wr(input int a, input logic [DW-1:0] d);
    wr_addr = AW'(a); wr_data = d; wr_addr_valid = 1'b1; wr_data_valid = 1'b1;
  endtask
  task automatic put_rd(input int a);
    rd_addr = AW'(a); rd_valid = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    chk(!out_valid, "R11 output cleared by reset", out_valid, 0);
    chk(desc_ready, "R11 burst abandoned by reset", desc_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    qh = qt; prev_stall = 0; expect_busy = 0; expect_free = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; desc_valid = 0; rd_valid = 0; wr_addr_valid = 0; wr_data_valid = 0;
    desc_word = '0; rd_addr = '0; wr_addr = '0; wr_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    do_reset();

    // Fill the whole store, then write past its end (R4, R6).
    rdy_mode = 0;
    for (int a = 0; a < DEP; a++) begin put_wr(a, DW'(a * 53 + 17)); run_until_taken(); end
    put_wr(16, 12'hABC); run_until_taken();
    put_wr(200, 12'h5A5); run_until_taken();
    put_wr(255, 12'h3C3); run_until_taken();
    drain();

    // Read everything including past the end, with backpressure (R3, R5, R6, R10).
    rdy_mode = 1;
    for (int a = 0; a < 20; a++) begin put_rd(a); run_until_taken(); end
    put_rd(255); run_until_taken();
    drain();

    // Bursts: inside, crossing the end, empty, longest (R1, R2, R5, R8, R9).
    put_desc(3, 5); run_until_taken();
    put_desc(13, 6); run_until_taken();
    put_desc(0, 0); run_until_taken();
    put_desc(1, 15); run_until_taken();
    drain();

    // All three channels at once: burst, then write, then read (R7, R12).
    put_desc(5, 3); put_wr(7, 12'h777); put_rd(7); run_until_taken();
    put_wr(9, 12'h999); put_rd(2); run_until_taken();
    put_rd(9); run_until_taken();
    drain();

    // Full stall during a burst (R10).
    rdy_mode = 2;
    put_desc(0, 4); run_until_taken();
    repeat (6) step_cycle();
    rdy_mode = 0;
    drain();

    // Reset in the middle of a stalled burst (R11).
    rdy_mode = 2;
    put_desc(2, 10); run_until_taken();
    repeat (3) step_cycle();
    do_reset();
    rdy_mode = 0;
    put_rd(2); run_until_taken();
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule